// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Detection

This block takes an asynchronous serial line and turns it into 8-bit or 9-bit characters. A clock enable runs at a fixed multiple of the bit rate, and the block samples the line on each enabled cycle. It qualifies a start bit at mid-bit, takes every data bit and the stop bit from their mid-bit samples, and holds the last character together with its framing and parity status. The held character stays until a read strobe releases it.

Parity is optional. When it is on, the parity bit is the top bit of the character itself, not a bit added after it, so the frame length does not change. A software-selectable rule decides when the idle detector starts counting. It can start as soon as the start bit is over, so that trailing ones and the stop bit count. Or it can start only once the stop bit has been sampled. An idle flag reports one full character time of quiet line. A single interrupt request combines the data-full and idle flags, each through its own enable.

Top module: `uart_idle_rx`

## Requirements
- R1: In 8-bit mode (`mode9_i`=0), a frame is one low start bit, 8 data bits LSB first and one stop bit. The character appears on `data_o[7:0]` with `data_o[8]`=0, and `full_o` is set.
- R2: In 9-bit mode (`mode9_i`=1), 9 data bits are received LSB first and presented on `data_o[8:0]`.
- R3: A low level that has ended by the mid-bit sample of the start bit is treated as noise. It produces no character and sets no flag.
- R4: With `par_en_i`=1, the top bit of the character (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is the parity bit and stays visible in `data_o`. `par_odd_i`=0 requires an even number of ones across the whole character, and `par_odd_i`=1 requires an odd number. A mismatch sets `par_err_o`. With `par_en_i`=0, `par_err_o` stays 0.
- R5: A stop bit sampled low sets `frame_err_o`. The receiver then waits for the line to go high before it looks for the next start bit.
- R6: `frame_err_o` and `par_err_o` are loaded together with each stored character. A one-cycle `rd_i` clears `full_o`.
- R7: If a character completes while `full_o` is 1 and `rd_i` is 0, `overrun_o` is set and the stored data and error flags are kept. `rd_i` clears `overrun_o`.
- R8: Idle requires the line to stay high for 10 bit times (16·10 oversample ticks by default) in 8-bit mode and 11 bit times in 9-bit mode.
- R9: With `idle_after_stop_i`=0, idle counting starts at the end of the start bit, so trailing data ones and the stop bit count. With `idle_after_stop_i`=1, counting starts only once the stop bit has been sampled.
- R10: Any low level on the line while idle is being counted restarts the count from zero.
- R11: `idle_o` is set at most once per idle period, and only after at least one character has been received since it was last set. `idle_clr_i` clears it. After reset it stays 0 until a character has been received.
- R12: `irq_o` is 1 exactly when (`full_o` and `rx_ie_i`) or (`idle_o` and `idle_ie_i`).
- R13: After reset, `data_o` and every flag and `irq_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversample enable, OSR pulses per bit time |
| rx_i | input | 1 | Serial line, idle high |
| mode9_i | input | 1 | 1: 9-bit characters, 0: 8-bit |
| par_en_i | input | 1 | Parity check enable |
| par_odd_i | input | 1 | 1: odd parity, 0: even |
| idle_after_stop_i | input | 1 | 1: idle count starts after stop bit, 0: after start bit |
| rx_ie_i | input | 1 | Interrupt enable for data-full |
| idle_ie_i | input | 1 | Interrupt enable for idle |
| rd_i | input | 1 | Read strobe, releases the stored character |
| idle_clr_i | input | 1 | Clears the idle flag |
| data_o | output | 9 | Stored character |
| full_o | output | 1 | Character waiting |
| idle_o | output | 1 | Idle line detected |
| frame_err_o | output | 1 | Stop bit was low |
| par_err_o | output | 1 | Parity mismatch |
| overrun_o | output | 1 | Character lost while full |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: OSR=16 and a two-stage input synchronizer, with the oversample enable held high. A bit therefore lasts 16 clocks. This gives the idle thresholds (160 and 176 high ticks) enough spacing that a single sampling point can tell 8-bit from 9-bit thresholds, and after-start from after-stop counting, with several clocks of margin on each side. That resolution also lets a 3-clock glitch be placed where it is rejected as a start bit but still restarts the idle count.

// File: rtl/uart_idle_rx_pkg.sv
package uart_idle_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BREAK
  } rx_state_e;

  typedef struct packed {
    logic [8:0] data;
    logic       fe;
    logic       pe;
  } rx_char_t;

endpackage

// File: rtl/uart_idle_rx_sync.sv
module uart_idle_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = q[STAGES-1];

endmodule

// File: rtl/uart_idle_rx_frame.sv
module uart_idle_rx_frame
  import uart_idle_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     mode9_i,
  input  logic     par_en_i,
  input  logic     par_odd_i,
  output logic     done_o,
  output rx_char_t char_o,
  output logic     busy_o
);

  localparam int            CW   = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic [3:0]    last_idx;
  logic          bit_end;
  logic [8:0]    chr;

  assign last_idx = mode9_i ? 4'd8 : 4'd7;
  assign bit_end  = tick_i && (cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!rx_i) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              state <= rx_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            sh[idx] <= rx_i;
            cnt     <= '0;
            if (idx == last_idx) state <= ST_STOP;
            else                 idx   <= idx + 1'b1;
          end else if (tick_i) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= rx_i ? ST_IDLE : ST_BREAK;
          end else if (tick_i) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BREAK: begin
          if (rx_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // parity bit occupies the msb of the character, so checking covers all bits
  assign chr         = mode9_i ? sh : {1'b0, sh[7:0]};
  assign done_o      = (state == ST_STOP) && bit_end;
  assign char_o.data = chr;
  assign char_o.fe   = !rx_i;
  assign char_o.pe   = par_en_i && ((^chr) ^ par_odd_i);
  assign busy_o      = (state != ST_IDLE);

endmodule

// File: rtl/uart_idle_rx_idle.sv
module uart_idle_rx_idle #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic mode9_i,
  input  logic after_stop_i,
  input  logic busy_i,
  input  logic done_i,
  input  logic clr_i,
  output logic idle_o
);

  localparam int W = $clog2(11 * OSR + 1);

  logic [W-1:0] cnt;
  logic [W-1:0] thr;
  logic         armed;
  logic         hit;

  assign thr = mode9_i ? W'(11 * OSR) : W'(10 * OSR);
  assign hit = armed && (cnt == thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
    end else if (!rx_i || (after_stop_i && busy_i)) begin
      cnt <= '0;
    end else if (tick_i && (cnt < thr)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed  <= 1'b0;
      idle_o <= 1'b0;
    end else begin
      if (done_i)   armed <= 1'b1;
      else if (hit) armed <= 1'b0;
      if (hit)        idle_o <= 1'b1;
      else if (clr_i) idle_o <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx
  import uart_idle_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       os_tick_i,
  input  logic       rx_i,
  input  logic       mode9_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       idle_after_stop_i,
  input  logic       rx_ie_i,
  input  logic       idle_ie_i,
  input  logic       rd_i,
  input  logic       idle_clr_i,
  output logic [8:0] data_o,
  output logic       full_o,
  output logic       idle_o,
  output logic       frame_err_o,
  output logic       par_err_o,
  output logic       overrun_o,
  output logic       irq_o
);

  logic     rx_s;
  logic     frame_done;
  logic     frame_busy;
  rx_char_t frame_char;
  logic     load;

  uart_idle_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_idle_rx_frame #(.OSR(OSR)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (os_tick_i),
    .rx_i     (rx_s),
    .mode9_i  (mode9_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .done_o   (frame_done),
    .char_o   (frame_char),
    .busy_o   (frame_busy)
  );

  uart_idle_rx_idle #(.OSR(OSR)) u_idle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (os_tick_i),
    .rx_i        (rx_s),
    .mode9_i     (mode9_i),
    .after_stop_i(idle_after_stop_i),
    .busy_i      (frame_busy),
    .done_i      (frame_done),
    .clr_i       (idle_clr_i),
    .idle_o      (idle_o)
  );

  // a read in the same cycle frees the holding register for the new character
  assign load = frame_done && (!full_o || rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      frame_err_o <= 1'b0;
      par_err_o   <= 1'b0;
      full_o      <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (load) begin
        data_o      <= frame_char.data;
        frame_err_o <= frame_char.fe;
        par_err_o   <= frame_char.pe;
        full_o      <= 1'b1;
      end else if (rd_i) begin
        full_o <= 1'b0;
      end
      if (frame_done && full_o && !rd_i) overrun_o <= 1'b1;
      else if (rd_i)                     overrun_o <= 1'b0;
    end
  end

  assign irq_o = (full_o && rx_ie_i) || (idle_o && idle_ie_i);

endmodule

// File: rtl/uart_idle_rx_chk.sv
module uart_idle_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       rx_ie_i,
  input logic       idle_ie_i,
  input logic       idle_after_stop_i,
  input logic       rx_s_i,
  input logic       done_i,
  input logic       busy_i,
  input logic [8:0] data_i,
  input logic       full_i,
  input logic       idle_i,
  input logic       overrun_i,
  input logic       irq_i
);

  p_load_from_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_i) |-> $past(done_i));

  p_overrun_needs_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_i) |-> $past(full_i));

  p_data_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && !rd_i) |=> $stable(data_i));

  p_read_clears_overrun_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !overrun_i);

  p_idle_on_high_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_i) |-> $past(rx_s_i));

  p_idle_after_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(idle_i) && idle_after_stop_i) |-> $past(!busy_i));

  p_irq_masked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ie_i && !idle_ie_i) |-> !irq_i);

endmodule

bind uart_idle_rx uart_idle_rx_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .rd_i             (rd_i),
  .rx_ie_i          (rx_ie_i),
  .idle_ie_i        (idle_ie_i),
  .idle_after_stop_i(idle_after_stop_i),
  .rx_s_i           (rx_s),
  .done_i           (frame_done),
  .busy_i           (frame_busy),
  .data_i           (data_o),
  .full_i           (full_o),
  .idle_i           (idle_o),
  .overrun_i        (overrun_o),
  .irq_i            (irq_o)
);

// File: tb/uart_idle_rx_tb.sv
module uart_idle_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;
  localparam int B          = OSR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       mode9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, after_stop = 1'b0;
  logic       rx_ie = 1'b0, idle_ie = 1'b0, rd = 1'b0, idle_clr = 1'b0;
  logic [8:0] data;
  logic       full, idle, fe, pe, ovr, irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_idle_rx #(.OSR(OSR), .SYNC_STAGES(2)) u_dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .os_tick_i        (1'b1),
    .rx_i             (rx),
    .mode9_i          (mode9),
    .par_en_i         (par_en),
    .par_odd_i        (par_odd),
    .idle_after_stop_i(after_stop),
    .rx_ie_i          (rx_ie),
    .idle_ie_i        (idle_ie),
    .rd_i             (rd),
    .idle_clr_i       (idle_clr),
    .data_o           (data),
    .full_o           (full),
    .idle_o           (idle),
    .frame_err_o      (fe),
    .par_err_o        (pe),
    .overrun_o        (ovr),
    .irq_o            (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model of the interrupt request (R12)
  always @(posedge clk) begin
    #2;
    chk("R12 irq per clock", int'(irq),
        int'((full && rx_ie) || (idle && idle_ie)));
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nb, input logic [8:0] v, input logic stop);
    @(negedge clk);
    rx = 1'b0;
    wait_cyc(B);
    for (int i = 0; i < nb; i++) begin
      rx = v[i];
      wait_cyc(B);
    end
    rx = stop;
    wait_cyc(B);
    rx = 1'b1;
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk);
    idle_clr = 1'b1;
    @(negedge clk);
    idle_clr = 1'b0;
  endtask

  task automatic send_chk(input string req, input int nb, input logic [8:0] v,
                          input int exp_pe);
    send(nb, v, 1'b1);
    wait_cyc(4);
    chk({req, " data"}, int'(data), int'(v));
    chk({req, " full"}, int'(full), 1);
    chk({req, " par_err"}, int'(pe), exp_pe);
    chk({req, " frame_err"}, int'(fe), 0);
    read_pulse();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    // R13 reset state
    chk("R13 data", int'(data), 0);
    chk("R13 flags", int'({full, idle, fe, pe, ovr, irq}), 0);

    // R1 8-bit receive
    send(8, 9'h0A5, 1'b1);
    wait_cyc(4);
    chk("R1 data", int'(data), 'h0A5);
    chk("R1 full", int'(full), 1);
    chk("R12 irq masked", int'(irq), 0);
    rx_ie = 1'b1;
    wait_cyc(1);
    chk("R12 irq on full", int'(irq), 1);
    rx_ie = 1'b0;
    read_pulse();
    wait_cyc(1);
    chk("R6 read clears full", int'(full), 0);

    // R2 9-bit receive
    mode9 = 1'b1;
    send_chk("R2 9-bit", 9, 9'h1C3, 0);
    mode9 = 1'b0;

    // R3 noise pulse shorter than half a bit
    @(negedge clk);
    rx = 1'b0;
    wait_cyc(3);
    rx = 1'b1;
    wait_cyc(3 * B);
    chk("R3 glitch no char", int'({full, fe, pe, ovr}), 0);

    // R7 overrun keeps first character
    send(8, 9'h011, 1'b1);
    send(8, 9'h022, 1'b1);
    wait_cyc(4);
    chk("R7 data kept", int'(data), 'h011);
    chk("R7 overrun", int'(ovr), 1);
    read_pulse();
    wait_cyc(1);
    chk("R7 read clears", int'({full, ovr}), 0);

    // R4 parity in the msb
    par_en = 1'b1;
    send_chk("R4 even ok", 8, 9'h003, 0);
    send_chk("R4 even bad", 8, 9'h007, 1);
    par_odd = 1'b1;
    send_chk("R4 odd ok", 8, 9'h007, 0);
    send_chk("R4 odd bad", 8, 9'h003, 1);
    par_odd = 1'b0;
    mode9 = 1'b1;
    send_chk("R4 9b even ok", 9, 9'h101, 0);
    send_chk("R4 9b even bad", 9, 9'h100, 1);
    mode9 = 1'b0;
    par_en = 1'b0;
    send_chk("R4 disabled", 8, 9'h007, 0);

    // R5 framing error and recovery
    send(8, 9'h055, 1'b0);
    wait_cyc(4);
    chk("R5 frame_err", int'(fe), 1);
    chk("R6 data with error", int'(data), 'h055);
    read_pulse();
    send_chk("R5 recovery", 8, 9'h05A, 0);

    // R8/R9 idle, 8-bit, count from start bit
    clr_pulse();
    send(8, 9'h0FF, 1'b1);
    wait_cyc(8);
    chk("R8 idle 8b early", int'(idle), 0);
    wait_cyc(16);
    chk("R8 idle 8b set", int'(idle), 1);
    read_pulse();

    // R8 idle, 9-bit needs one more bit time
    clr_pulse();
    mode9 = 1'b1;
    send(9, 9'h1FF, 1'b1);
    wait_cyc(8);
    chk("R8 idle 9b early", int'(idle), 0);
    wait_cyc(32);
    chk("R8 idle 9b set", int'(idle), 1);
    mode9 = 1'b0;
    read_pulse();

    // R9 count from stop bit
    clr_pulse();
    after_stop = 1'b1;
    send(8, 9'h0FF, 1'b1);
    wait_cyc(80);
    chk("R9 after stop early", int'(idle), 0);
    wait_cyc(96);
    chk("R9 after stop set", int'(idle), 1);
    idle_ie = 1'b1;
    wait_cyc(1);
    chk("R12 irq on idle", int'(irq), 1);
    idle_ie = 1'b0;
    after_stop = 1'b0;
    read_pulse();

    // R11 no second idle without a new character
    clr_pulse();
    wait_cyc(40 * B);
    chk("R11 once per period", int'(idle), 0);

    // R10 low pulse restarts the count
    send(8, 9'h0FF, 1'b1);
    wait_cyc(8);
    rx = 1'b0;
    wait_cyc(3);
    rx = 1'b1;
    wait_cyc(49);
    chk("R10 count restarted", int'(idle), 0);
    chk("R3 restart glitch no char", int'(ovr), 0);
    wait_cyc(140);
    chk("R10 idle after restart", int'(idle), 1);
    read_pulse();

    // R11 after reset, idle needs a character first
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(30 * B);
    chk("R11 no idle after reset", int'(idle), 0);
    chk("R13 flags after reset", int'({full, fe, pe, ovr, data}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule